// File: doc/BRIEF.md
# Parallel Prefix Sum Scanner

The block takes a vector of N unsigned words in one cycle and turns it into the vector of its inclusive running sums. Output element i ends up holding the sum of input elements 0 through i. The block does not walk the vector with one accumulator. It uses a doubling-offset scan instead. Each element sits in its own register, and on every scan cycle every element may add in the element a fixed distance below it. That distance doubles from one cycle to the next, so the whole vector is done in log2(N) cycles.

A caller presents all N words on `din` and pulses `start` while the block is idle. The block then steps through its levels with `busy` high. It raises `done` for one cycle when the last level has been written, and the results then stay on `dout` until the next accepted start. Sums wrap at the word width, and no overflow indication is given. N must be a power of two and at least 2.

Top module: `pfx_scan`

## Requirements
- R1: While reset is low and on the cycle after it is released, `dout` is all zeros and `busy` and `done` are low.
- R2: A `start` sampled high while `busy` is low copies `din` into the element registers. After that edge `dout` equals `din`, with element i in bits [i*W +: W], and `busy` is high.
- R3: `done` is high for exactly one cycle. It rises on the log2(N)-th rising edge after the edge that sampled the accepted `start`, and `busy` is low from that edge on.
- R4: When `done` is high, element i of `dout` equals the sum of `din` elements 0..i as they were at the accepted start, modulo 2^W.
- R5: On scan level j, counted from 0 on the first edge after the load, every element i >= 2^j becomes its own previous value plus the previous value of element i-2^j. All elements use values from before that edge.
- R6: On scan level j, every element i < 2^j keeps its value. Element 0 therefore never changes during a scan.
- R7: A `start` that arrives while `busy` is high is ignored. The running scan keeps its timing and its result, and the `din` present at that moment is not loaded.
- R8: Every addition wraps modulo 2^W, and no other output reports a carry.
- R9: While idle with no start, the element registers hold their values whatever `din` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load pulse, accepted only while idle |
| din | input | N*W | Input vector, element i in bits [i*W +: W] |
| dout | output | N*W | Element registers, element i in bits [i*W +: W] |
| busy | output | 1 | High while scan levels are running |
| done | output | 1 | One-cycle pulse after the last level |

## Verification
Each pattern exposes a different class of fault:
- All ones: the final value of element i must equal i+1, so a missed or repeated level shows up as a wrong count.
- Ascending ramp: a wrong partner offset gives a different sum, because no two elements hold the same value.
- A single nonzero word at index 0: only this pattern shows whether the value reaches every higher element.
- A single nonzero word at the top index: the value must stay where it is, so any element that reads from above itself is caught.
- All words near the maximum: carries must be dropped at the word width.
- Random vectors: a cycle-accurate model compares the intermediate level values on every clock.
- A second start during a scan, and a moving `din` while idle: neither may disturb the registers.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  // Scan sequencer phases.
  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_SCAN = 1'b1
  } pfx_phase_e;

  // Number of doubling levels for an N-element vector.
  function automatic int unsigned pfx_levels(input int unsigned n);
    return $clog2(n);
  endfunction

  // Width of a counter able to index every level (at least one bit).
  function automatic int unsigned pfx_lvl_bits(input int unsigned n);
    int unsigned l;
    l = $clog2(n);
    return (l > 1) ? $clog2(l) : 1;
  endfunction

  // Distance between an element and its partner on a given level.
  function automatic int unsigned pfx_offset(input int unsigned level);
    return 32'd1 << level;
  endfunction

endpackage

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
  import pfx_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  output logic                             load,
  output logic                             step,
  output logic [pfx_lvl_bits(N)-1:0]       lvl,
  output logic                             busy,
  output logic                             done
);

  localparam int unsigned L   = pfx_levels(N);
  localparam int unsigned LVW = pfx_lvl_bits(N);

  pfx_phase_e           phase_q;
  logic [LVW-1:0]       lvl_q;
  logic                 done_q;
  logic                 last_lvl;

  assign last_lvl = (lvl_q == LVW'(L - 1));
  assign load     = start && (phase_q == PH_IDLE);
  assign step     = (phase_q == PH_SCAN);
  assign lvl      = lvl_q;
  assign busy     = (phase_q == PH_SCAN);
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      lvl_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SCAN;
            lvl_q   <= '0;
          end
        end
        PH_SCAN: begin
          if (last_lvl) begin
            phase_q <= PH_IDLE;
            lvl_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            lvl_q <= LVW'(lvl_q + 1'b1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_LOAD_STARTS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && lvl == '0)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_lvl) |=> (done && !busy)); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_lvl) |=> (busy && lvl == LVW'($past(lvl) + 1'b1))); // R7

endmodule

// File: rtl/pfx_route.sv
module pfx_route
  import pfx_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]               vals    [N],
  input  logic [pfx_lvl_bits(N)-1:0] lvl,
  output logic [W-1:0]               partner [N],
  output logic                       take    [N]
);

  localparam int unsigned L   = pfx_levels(N);
  localparam int unsigned LVW = pfx_lvl_bits(N);

  logic [W-1:0] cand [N][L];
  logic         has  [N][L];

  for (genvar i = 0; i < N; i++) begin : g_el
    for (genvar j = 0; j < L; j++) begin : g_lv
      if (i >= pfx_offset(j)) begin : g_src
        assign cand[i][j] = vals[i - pfx_offset(j)];
        assign has[i][j]  = 1'b1;
      end else begin : g_none
        assign cand[i][j] = '0;
        assign has[i][j]  = 1'b0;
      end
    end

    always_comb begin
      partner[i] = '0;
      take[i]    = 1'b0;
      for (int j = 0; j < L; j++) begin
        if (lvl == LVW'(j)) begin
          partner[i] = cand[i][j];
          take[i]    = has[i][j];
        end
      end
    end
  end

endmodule

// File: rtl/pfx_lane.sv
module pfx_lane #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         take,
  input  logic [W-1:0] din,
  input  logic [W-1:0] partner,
  output logic [W-1:0] val
);

  // Sum truncated to the word width; the carry is dropped.
  function automatic logic [W-1:0] add_wrap(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[W-1:0];
  endfunction

  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load) begin
      val_q <= din;
    end else if (step && take) begin
      val_q <= add_wrap(val_q, partner);
    end
  end

  assign val = val_q;

  AST_LANE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val == $past(din))); // R2

  AST_LANE_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !take && !load) |=> $stable(val)); // R6

  AST_LANE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(val)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && take && !load) |=> (val == W'($past(val) + $past(partner)))); // R8

endmodule

// File: rtl/pfx_scan.sv
module pfx_scan
  import pfx_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*W-1:0] din,
  output logic [N*W-1:0] dout,
  output logic           busy,
  output logic           done
);

  localparam int unsigned L   = pfx_levels(N);
  localparam int unsigned LVW = pfx_lvl_bits(N);

  logic           load;
  logic           step;
  logic [LVW-1:0] lvl;
  logic [W-1:0]   el_val  [N];
  logic [W-1:0]   el_din  [N];
  logic [W-1:0]   el_prt  [N];
  logic           el_take [N];

  pfx_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .lvl   (lvl),
    .busy  (busy),
    .done  (done)
  );

  pfx_route #(.N(N), .W(W)) u_route (
    .vals    (el_val),
    .lvl     (lvl),
    .partner (el_prt),
    .take    (el_take)
  );

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign el_din[i]        = din[i*W +: W];
    assign dout[i*W +: W]   = el_val[i];

    pfx_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .step    (step),
      .take    (el_take[i]),
      .din     (el_din[i]),
      .partner (el_prt[i]),
      .val     (el_val[i])
    );
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3

  AST_LANE0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (el_val[0] == $past(el_val[0]))); // R6

  initial begin
    assert (N >= 2 && (N & (N - 1)) == 0 && L >= 1)
      else $error("pfx_scan: N must be a power of two, at least 2");
  end

endmodule

// File: tb/test_pfx_scan.sv
module test_pfx_scan;

  localparam int N = 8;
  localparam int W = 16;
  localparam int L = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [N*W-1:0] din;
  logic [N*W-1:0] dout;
  logic           busy;
  logic           done;

  always #2.5 clk = ~clk;

  pfx_scan #(.N(N), .W(W)) i_pfx_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .dout(dout), .busy(busy), .done(done)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [W-1:0] stim [N];

  // Cycle-level behavioural model of the register contents.
  logic [W-1:0] m_val [N];
  logic [W-1:0] m_old [N];
  bit m_busy, m_done;
  int m_lvl;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_val[k]) m_val[k] = '0;
      m_busy = 0; m_done = 0; m_lvl = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        foreach (m_val[k]) m_old[k] = m_val[k];
        for (int k = 0; k < N; k++)
          if (k >= (1 << m_lvl)) m_val[k] = W'(int'(m_old[k]) + int'(m_old[k - (1 << m_lvl)]));
        if (m_lvl == L - 1) begin m_busy = 0; m_done = 1; m_lvl = 0; end
        else m_lvl++;
      end else if (start) begin
        for (int k = 0; k < N; k++) m_val[k] = din[k*W +: W];
        m_busy = 1; m_lvl = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Every clock: compare against the model (R5 on scan levels).
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      logic [N*W-1:0] e;
      for (int k = 0; k < N; k++) e[k*W +: W] = m_val[k];
      check(dout === e && busy === m_busy && done === m_done,
            m_busy ? "R5" : (m_done ? "R4" : "R9"), "per-cycle model",
            {dout, busy, done}, {e, m_busy, m_done});
    end
  end

  task automatic apply_stim();
    for (int k = 0; k < N; k++) din[k*W +: W] = stim[k];
  endtask

  // Runs one scan from the current stim; optionally pokes start mid-scan (R7).
  task automatic run_scan(input bit poke, input string name);
    logic [N*W-1:0] exp;
    logic [W-1:0] acc;
    logic [W-1:0] first;
    int seen;
    acc = '0;
    for (int k = 0; k < N; k++) begin
      acc = W'(int'(acc) + int'(stim[k]));   // serial running sum, R8 wrap
      exp[k*W +: W] = acc;
    end
    first = stim[0];
    @(negedge clk);
    apply_stim();
    start = 1'b1;
    seen = 0;
    for (int k = 1; k <= 20 && seen == 0; k++) begin
      @(negedge clk);
      if (k == 1) begin
        check(busy === 1'b1 && dout === din, "R2", {name, " load"}, dout, din);
        if (poke) begin start = 1'b1; din = ~din; end
        else start = 1'b0;
      end else begin
        start = 1'b0;
      end
      if (busy === 1'b1)
        check(dout[W-1:0] === first, "R6", {name, " element 0 fixed"}, dout[W-1:0], first);
      if (done === 1'b1) seen = k;
    end
    check(seen == L + 1, poke ? "R7" : "R3", {name, " done timing"}, seen, L + 1);
    check(dout === exp, poke ? "R7" : "R4", {name, " prefix sums"}, dout, exp);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R3", {name, " done one cycle"}, done, 0);
    din = ~din;
    repeat (3) @(negedge clk);
    check(dout === exp, "R9", {name, " hold while idle"}, dout, exp);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; din = '1;
    repeat (3) @(negedge clk);
    check(dout === '0 && busy === 1'b0 && done === 1'b0, "R1", "in reset", dout, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout === '0 && busy === 1'b0 && done === 1'b0, "R1", "after reset", dout, '0);

    foreach (stim[k]) stim[k] = 16'd1;
    run_scan(0, "ones");
    foreach (stim[k]) stim[k] = W'(k * 3 + 5);
    run_scan(0, "ramp");
    foreach (stim[k]) stim[k] = (k == 0) ? 16'h0042 : 16'h0;
    run_scan(0, "low spike");
    foreach (stim[k]) stim[k] = (k == N - 1) ? 16'h0777 : 16'h0;
    run_scan(0, "top spike");
    foreach (stim[k]) stim[k] = 16'hFFF0 + W'(k);
    run_scan(0, "R8 wrap");
    foreach (stim[k]) stim[k] = W'(k + 1);
    run_scan(1, "restart ignored");
    for (int r = 0; r < 6; r++) begin
      foreach (stim[k]) stim[k] = W'($urandom);
      run_scan(0, "random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    finished = 1'b1;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule